// File: doc/BRIEF.md
# Display Timing Interrupt Event Generator

This block keeps track of where a raster scan is within a frame. It counts clock ticks within a line and lines within a frame. It then raises three single-cycle event pulses for an interrupt controller. The vertical-blank event marks the first line of the blanking region. The horizontal-blank event marks the start of the blanking part of each line. The line-match event fires when the line counter equals a compare value that software can program. A single 16-bit configuration word holds three enable bits and the compare value. The same word, with three live flags added, is presented on a status output.

Position is tracked by two small state machines. The horizontal machine moves from `H_ACTIVE` to `H_BLANK` on the tick before `HBLANK_TICK`, and goes back to `H_ACTIVE` on the last tick of the line. The vertical machine moves from `V_ACTIVE` to `V_BLANK` at the end of line `VBLANK_LINE-1`, and goes back to `V_ACTIVE` at the end of line `LINES-1`. A third machine tracks the compare. It moves from `M_MISS` to `M_HIT` when the line and compare values that will hold after the next edge are equal, and goes back to `M_MISS` when they differ. Each event pulse is registered on the entry into `H_BLANK`, `V_BLANK` or `M_HIT`. The pulse is then gated by its enable bit as that bit reads in the same cycle.

The default geometry is 1232 ticks per line, horizontal blank from tick 960, 228 lines per frame and vertical blank from line 160. All four values are parameters.

Top module: `disp_evt_gen`

## Requirements
- R1: While reset is held, `line_out` is 0, all three event outputs are 0 and `status` reads 16'h0004. Line 0 equals the reset compare value 0, so the match flag is set and no other bit is.
- R2: The tick counter advances every cycle and wraps after `LINE_TICKS` ticks. `line_out` advances by one at each wrap and goes from `LINES-1` back to 0.
- R3: `status[1]` (horizontal blank) is 1 exactly while the tick is at or above `HBLANK_TICK`. `hblank_irq` pulses in the first cycle of that span on every line, including the lines inside vertical blank.
- R4: `status[0]` (vertical blank) is 1 exactly while the line is at or above `VBLANK_LINE`. `vblank_irq` pulses only in the first cycle (tick 0) of line `VBLANK_LINE`, once per frame.
- R5: `status[2]` (match) is 1 exactly when `line_out` equals the compare value. `match_irq` pulses in the first cycle this becomes true. This includes a compare write that lands on the current line. A compare value of `LINES` or more never matches.
- R6: Each event is gated by its own enable as it reads in the same cycle: `status[3]` gates vertical blank, `status[4]` gates horizontal blank and `status[5]` gates match. With an enable at 0, that event never pulses while its flag keeps working.
- R7: A write with `cfg_we` loads `cfg_wdata[15:8]` as the compare value and `cfg_wdata[5:3]` as the enables, visible from the next cycle. Bits 2:0 of the write are ignored, because they are driven by the flags. Bits 7:6 of `status` always read 0.
- R8: Every event output is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data: compare in 15:8, enables in 5:3 |
| status | output | 16 | Compare, enables and flags (vblank bit 0, hblank bit 1, match bit 2) |
| line_out | output | 8 | Current line number |
| vblank_irq | output | 1 | Vertical-blank event pulse |
| hblank_irq | output | 1 | Horizontal-blank event pulse |
| match_irq | output | 1 | Line-match event pulse |

## Verification
The hardest case to reach is a compare write that lands on the line currently being scanned. The match must then rise partway through the line and pulse at once, rather than waiting for the next line change. The bench keeps its own cycle count since reset, so it knows which line will be current after the write edge. It writes exactly that value after first parking the compare out of range. The horizontal-blank pulses inside vertical blank are counted separately over one full frame.

// File: rtl/disp_evt_pkg.sv
package disp_evt_pkg;

    localparam int LINE_W   = 8;
    localparam int NUM_EV   = 3;
    localparam int EV_VBL   = 0;
    localparam int EV_HBL   = 1;
    localparam int EV_MATCH = 2;

    typedef enum logic {H_ACTIVE, H_BLANK} h_state_e;
    typedef enum logic {V_ACTIVE, V_BLANK} v_state_e;
    typedef enum logic {M_MISS, M_HIT}     m_state_e;

    typedef struct packed {
        logic [LINE_W-1:0] cmp;
        logic              en_match;
        logic              en_hbl;
        logic              en_vbl;
    } disp_cfg_t;

endpackage

// File: rtl/disp_hfsm.sv
module disp_hfsm
    import disp_evt_pkg::*;
#(
    parameter int LINE_TICKS  = 1232,
    parameter int HBLANK_TICK = 960
) (
    input  logic clk,
    input  logic rst_n,
    output logic line_end,
    output logic hblank,
    output logic hbl_start
);
    localparam int DOT_W = $clog2(LINE_TICKS);
    localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(LINE_TICKS - 1);
    localparam logic [DOT_W-1:0] HB_PRE   = DOT_W'(HBLANK_TICK - 1);

    logic [DOT_W-1:0] dot_q, dot_nxt;
    h_state_e         h_q, h_nxt;
    logic             start_q;

    assign line_end = (dot_q == DOT_LAST);
    assign dot_nxt  = line_end ? '0 : dot_q + 1'b1;

    // next-state decode
    always_comb begin
        h_nxt = h_q;
        unique case (h_q)
            H_ACTIVE: if (dot_q == HB_PRE)   h_nxt = H_BLANK;
            H_BLANK:  if (dot_q == DOT_LAST) h_nxt = H_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q   <= H_ACTIVE;
            dot_q <= '0;
        end else begin
            h_q   <= h_nxt;
            dot_q <= dot_nxt;
        end
    end

    // outputs: pulse registered on entry into blank
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= (h_q == H_ACTIVE) && (h_nxt == H_BLANK);
    end

    assign hblank    = (h_q == H_BLANK);
    assign hbl_start = start_q;

endmodule

// File: rtl/disp_vfsm.sv
module disp_vfsm
    import disp_evt_pkg::*;
#(
    parameter int LINES       = 228,
    parameter int VBLANK_LINE = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] line_nxt,
    output logic              vblank,
    output logic              vbl_start
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] VB_PRE    = LINE_W'(VBLANK_LINE - 1);

    v_state_e v_q, v_nxt;
    logic     start_q;

    always_comb begin
        line_nxt = line_q;
        if (line_end) line_nxt = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    end

    always_comb begin
        v_nxt = v_q;
        unique case (v_q)
            V_ACTIVE: if (line_end && line_q == VB_PRE)    v_nxt = V_BLANK;
            V_BLANK:  if (line_end && line_q == LINE_LAST) v_nxt = V_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= V_ACTIVE;
            line_q <= '0;
        end else begin
            v_q    <= v_nxt;
            line_q <= line_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= (v_q == V_ACTIVE) && (v_nxt == V_BLANK);
    end

    assign vblank    = (v_q == V_BLANK);
    assign vbl_start = start_q;

endmodule

// File: rtl/disp_line_match.sv
module disp_line_match
    import disp_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_nxt,
    input  logic [LINE_W-1:0] cmp_nxt,
    output logic              match,
    output logic              match_start
);
    m_state_e m_q, m_nxt;
    logic     start_q;

    always_comb begin
        m_nxt = m_q;
        unique case (m_q)
            M_MISS: if (line_nxt == cmp_nxt) m_nxt = M_HIT;
            M_HIT:  if (line_nxt != cmp_nxt) m_nxt = M_MISS;
        endcase
    end

    // reset: line 0 equals reset compare 0
    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= M_HIT;
        else        m_q <= m_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= (m_q == M_MISS) && (m_nxt == M_HIT);
    end

    assign match       = (m_q == M_HIT);
    assign match_start = start_q;

endmodule

// File: rtl/disp_evt_gen.sv
module disp_evt_gen
    import disp_evt_pkg::*;
#(
    parameter int LINE_TICKS  = 1232,
    parameter int HBLANK_TICK = 960,
    parameter int LINES       = 228,
    parameter int VBLANK_LINE = 160
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] status,
    output logic [7:0]  line_out,
    output logic        vblank_irq,
    output logic        hblank_irq,
    output logic        match_irq
);
    disp_cfg_t         cfg_q, cfg_nxt;
    logic              line_end, hblank, vblank, match;
    logic              hbl_start, vbl_start, match_start;
    logic [LINE_W-1:0] line_q, line_nxt;
    logic [NUM_EV-1:0] ev_raw, ev_en, ev_out;
    logic              unused_wbits;

    assign unused_wbits = ^{cfg_wdata[7:6], cfg_wdata[2:0]};

    always_comb begin
        cfg_nxt = cfg_q;
        if (cfg_we) begin
            cfg_nxt.cmp      = cfg_wdata[15:8];
            cfg_nxt.en_match = cfg_wdata[5];
            cfg_nxt.en_hbl   = cfg_wdata[4];
            cfg_nxt.en_vbl   = cfg_wdata[3];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_nxt;
    end

    disp_hfsm #(.LINE_TICKS(LINE_TICKS), .HBLANK_TICK(HBLANK_TICK)) u_hfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .hblank    (hblank),
        .hbl_start (hbl_start)
    );

    disp_vfsm #(.LINES(LINES), .VBLANK_LINE(VBLANK_LINE)) u_vfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .line_q    (line_q),
        .line_nxt  (line_nxt),
        .vblank    (vblank),
        .vbl_start (vbl_start)
    );

    disp_line_match u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_nxt    (line_nxt),
        .cmp_nxt     (cfg_nxt.cmp),
        .match       (match),
        .match_start (match_start)
    );

    assign ev_raw[EV_VBL]   = vbl_start;
    assign ev_raw[EV_HBL]   = hbl_start;
    assign ev_raw[EV_MATCH] = match_start;
    assign ev_en[EV_VBL]    = cfg_q.en_vbl;
    assign ev_en[EV_HBL]    = cfg_q.en_hbl;
    assign ev_en[EV_MATCH]  = cfg_q.en_match;

    for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_gate
        assign ev_out[gi] = ev_raw[gi] & ev_en[gi];
    end

    assign vblank_irq = ev_out[EV_VBL];
    assign hblank_irq = ev_out[EV_HBL];
    assign match_irq  = ev_out[EV_MATCH];
    assign line_out   = line_q;
    assign status     = {cfg_q.cmp, 2'b00, cfg_q.en_match, cfg_q.en_hbl,
                         cfg_q.en_vbl, match, hblank, vblank};

endmodule

// File: rtl/disp_evt_chk.sv
module disp_evt_chk #(
    parameter int LINES       = 228,
    parameter int VBLANK_LINE = 160
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] status,
    input logic [7:0]  line_out,
    input logic        vblank_irq,
    input logic        hblank_irq,
    input logic        match_irq
);
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out != $past(line_out)) |->
        (line_out == (($past(line_out) == 8'(LINES - 1)) ? 8'd0 : $past(line_out) + 8'd1)));

    p_hbl_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_irq |-> (status[1] && !$past(status[1])));

    p_vbl_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> (status[0] && line_out == 8'(VBLANK_LINE)));

    p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] == (line_out == status[15:8]));

    p_gate_vbl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> status[3]);
    p_gate_hbl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_irq |-> status[4]);
    p_gate_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> (status[5] && status[2]));

    p_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:6] == 2'b00);

    p_single_vbl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |=> !vblank_irq);
    p_single_hbl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_irq |=> !hblank_irq);
    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq);

endmodule

bind disp_evt_gen disp_evt_chk #(.LINES(LINES), .VBLANK_LINE(VBLANK_LINE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status),
    .line_out   (line_out),
    .vblank_irq (vblank_irq),
    .hblank_irq (hblank_irq),
    .match_irq  (match_irq)
);

// File: tb/disp_evt_gen_tb_top.sv
`timescale 1ns/1ps
module disp_evt_gen_tb_top;
    localparam int T = 20;
    localparam int H = 14;
    localparam int L = 10;
    localparam int V = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] status;
    logic [7:0]  line_out;
    logic        vblank_irq, hblank_irq, match_irq;

    int checks = 0;
    int fails  = 0;
    int cnt_v, cnt_h, cnt_hv, cnt_m, cnt_dbl;
    logic prev_any;

    always #10 clk = ~clk;

    disp_evt_gen #(.LINE_TICKS(T), .HBLANK_TICK(H), .LINES(L), .VBLANK_LINE(V)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .status     (status),
        .line_out   (line_out),
        .vblank_irq (vblank_irq),
        .hblank_irq (hblank_irq),
        .match_irq  (match_irq)
    );

    // independent model: cycles since reset and shadow of the writable fields
    int          k;
    logic [15:0] sh;
    logic        mprev;
    int          e_dot, e_line;
    logic        e_m;

    always_comb begin
        e_dot  = k % T;
        e_line = (k / T) % L;
        e_m    = (e_line == int'(sh[15:8]));
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            k <= 0; sh <= '0; mprev <= 1'b1;
        end else begin
            k <= k + 1;
            if (cfg_we) sh <= cfg_wdata & 16'hFF38;
            mprev <= e_m;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (line %0d tick %0d)", req, act, exp, e_line, e_dot);
        end
    endtask

    task automatic check_now();
        chk("R2 line", int'(line_out), e_line);
        chk("R3 hblank", int'({status[1], hblank_irq}),
            int'({e_dot >= H, (e_dot == H) && sh[4]}));
        chk("R4 vblank", int'({status[0], vblank_irq}),
            int'({e_line >= V, (e_line == V) && (e_dot == 0) && sh[3]}));
        chk("R5 match", int'({status[2], match_irq}),
            int'({e_m, e_m && !mprev && sh[5]}));
        chk("R7 fields", int'(status[15:3]), int'({sh[15:8], 2'b00, sh[5:3]}));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #5;
            check_now();
            if (vblank_irq) cnt_v++;
            if (hblank_irq) cnt_h++;
            if (hblank_irq && e_line >= V) cnt_hv++;
            if (match_irq) cnt_m++;
            if (prev_any && (vblank_irq || hblank_irq || match_irq)) cnt_dbl++;
            prev_any = vblank_irq || hblank_irq || match_irq;
        end
    endtask

    task automatic wr(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        run(1);
        cfg_we = 1'b0;
    endtask

    task automatic clr();
        cnt_v = 0; cnt_h = 0; cnt_hv = 0; cnt_m = 0; cnt_dbl = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1 status", int'(status), 16'h0004);
        chk("R1 line", int'(line_out), 0);
        chk("R1 irqs", int'({vblank_irq, hblank_irq, match_irq}), 0);
        rst_n = 1'b1;
        prev_any = 1'b0;
        run(3);
    endtask

    task automatic t_hblank_every_line();
        wr(16'h0010);
        clr(); run(T * L);
        chk("R3 hblank pulses per frame", cnt_h, L);
        chk("R3 hblank pulses inside vblank", cnt_hv, L - V);
        chk("R6 others gated", cnt_v + cnt_m, 0);
    endtask

    task automatic t_vblank_once();
        wr(16'h0008);
        clr(); run(T * L);
        chk("R4 vblank pulses per frame", cnt_v, 1);
        chk("R6 hblank gated", cnt_h, 0);
    endtask

    task automatic t_match();
        wr(16'h0320);
        clr(); run(T * L);
        chk("R5 match pulses cmp=3", cnt_m, 1);
        wr(16'hC820);
        clr(); run(T * L);
        chk("R5 out-of-range compare", cnt_m + int'(status[2]), 0);
    endtask

    task automatic t_match_midline();
        int tgt;
        wr(16'hC820);
        run(T / 2 - 3);
        tgt = ((k + 1) / T) % L;
        clr();
        wr({8'(tgt), 8'h20});
        chk("R5 midline write flag", int'(status[2]), 1);
        chk("R5 midline write pulse", int'(match_irq), 1);
        run(2);
        chk("R5 midline single pulse", cnt_m, 1);
    endtask

    task automatic t_readonly_bits();
        wr(16'h00C7);
        chk("R7 low write bits ignored", int'(status[7:3]), 0);
        run(T * 2);
    endtask

    task automatic t_gating();
        wr(16'h0238);
        clr(); run(T * L);
        chk("R6 all on: vblank", cnt_v, 1);
        chk("R6 all on: hblank", cnt_h, L);
        chk("R6 all on: match", cnt_m, 1);
        wr(16'h0200);
        clr(); run(T * L);
        chk("R6 all off: no pulses", cnt_v + cnt_h + cnt_m, 0);
    endtask

    task automatic t_single();
        chk("R8 no back-to-back pulses", cnt_dbl, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        prev_any = 1'b0;
        clr();
        t_reset();
        t_hblank_every_line();
        t_vblank_once();
        t_match();
        t_match_midline();
        t_readonly_bits();
        clr();
        t_gating();
        t_single();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule